// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block sits beside a program sequencer with 14-bit program addresses and decides which interrupt the sequencer should take next. It gathers nine request sources: a start-up request raised by reset, three active-low external pins, two host-port events, two serial-port events and a timer event. Each source passes through its own detection stage (edge latch or live level), a software force and clear path, and a mask. A fixed-priority selector then picks one source and presents its vector address, which is the source index times four.

The sequencer answers with two single-cycle pulses. An acknowledge takes the presented source: its latched request is retired, it is marked as in service, and the arithmetic status word supplied by the sequencer is pushed onto a status stack together with the block's own mask and mode-status registers. A return pulse ends the service routine entered most recently, pops the stack, restores mask and mode status from it and hands the saved arithmetic status back to the sequencer. A control bit chooses between nested servicing, where a more urgent request can interrupt a running routine, and one-at-a-time servicing.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is held and after it is released, the mask and mode-status registers read zero, both error flags are clear and the start-up request is presented with vector 0x0000; once it is acknowledged no other source is presented until the mask is written.
- R2: Source index k is presented with vector k*4; index 0 start-up, 1 pin IRQ2, 2 host write, 3 host read, 4 serial-0 transmit, 5 serial-0 receive, 6 serial-1 transmit or pin IRQ1, 7 serial-1 receive or pin IRQ0, 8 timer; a lower index always wins over a higher one.
- R3: Source k (1 to 8) can be presented only while mask bit k-1 is 1; the start-up request ignores the mask.
- R4: Control bits 0, 1 and 2 set pins IRQ0, IRQ1 and IRQ2 to edge mode when 1; in edge mode a high-to-low pin transition latches a request that stays after the pin returns high and is retired by the acknowledge of that source.
- R5: In level mode (control bit 0) a pin source is requesting exactly while its pin is low; an acknowledge does not retire it.
- R6: A force/clear write sets (force bit k-1) or retires (clear bit k-1) the latched request of source k; it has no effect on the two host-port sources or on a pin source in level mode.
- R7: With control bit 4 at 0, no source other than start-up is presented while any service routine is active.
- R8: With control bit 4 at 1, a source is presented only if its priority is higher than every active routine; a return ends the highest-priority active routine.
- R9: An acknowledge of source 1 to 8 pushes {arithmetic status input, mode status, mask}; a return pops the top entry, restores mask and mode status from it at the same clock edge and shows the saved arithmetic status with a one-cycle valid pulse.
- R10: A push onto a full stack sets a sticky overflow flag, a pop of an empty stack sets a sticky underflow flag, and in both cases the stored entries, mask and mode status stay as they were.
- R11: A new edge or event on a source in the cycle it is acknowledged leaves it requesting; an acknowledge in the same cycle as a return is ignored.
- R12: With altPins at 1, sources 6 and 7 come from pins IRQ1 and IRQ0 and their serial events are ignored; with altPins at 0 the pins are ignored and the serial events feed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqN | input | 3 | External pins, active low: bit 0 IRQ0, bit 1 IRQ1, bit 2 IRQ2 |
| periphEvt | input | 7 | Event pulses, bit j feeds source j+2 |
| altPins | input | 1 | Sources 6 and 7 taken from pins instead of serial events |
| maskWe | input | 1 | Mask write strobe |
| maskWdata | input | 8 | Mask value, bit k-1 enables source k |
| ctrlWe | input | 1 | Control write strobe |
| ctrlWdata | input | 5 | Bits 2:0 edge mode per pin, bit 4 nesting |
| mstatWe | input | 1 | Mode-status write strobe |
| mstatWdata | input | 7 | Mode-status value |
| fcWe | input | 1 | Force/clear write strobe |
| fcForce | input | 8 | Force bit k-1 for source k |
| fcClear | input | 8 | Clear bit k-1 for source k |
| astatIn | input | 8 | Arithmetic status to save on acknowledge |
| ack | input | 1 | Sequencer takes the presented vector |
| rti | input | 1 | Sequencer returns from a service routine |
| irqValid | output | 1 | A vector is presented |
| vecAddr | output | 14 | Vector address of the selected source |
| maskOut | output | 8 | Current mask |
| mstatOut | output | 7 | Current mode status |
| popValid | output | 1 | popAstat holds a restored value |
| popAstat | output | 8 | Arithmetic status from the last pop |
| ovfErr | output | 1 | Sticky stack overflow |
| unfErr | output | 1 | Sticky stack underflow |

## Verification
Two collisions matter here. The first is an acknowledge landing in the same cycle as a fresh falling edge on the acknowledged pin: the bench drops the pin exactly on the acknowledge cycle and, after the routine returns, expects the same vector again rather than silence. The second is an acknowledge and a return arriving together with an idle stack: the bench expects the underflow flag from the return while the pending timer request is still presented afterwards, showing the acknowledge was dropped.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int SRC_N = 9;
  localparam int SRC_IDX_W = 4;
  localparam int MASK_W = SRC_N - 1;

  typedef struct packed {
    logic [SRC_N-1:0] ackHot;
    logic push;
    logic pop;
  } vecStrobe_t;
endpackage

// File: rtl/irq_vector_dp.sv
module irq_vector_dp
  import irq_vector_pkg::*;
#(
  parameter int ASTAT_W = 8,
  parameter int MSTAT_W = 7,
  parameter int STACK_DEPTH = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         irqN,
  input  logic [6:0]         periphEvt,
  input  logic               altPins,
  input  logic               maskWe,
  input  logic [MASK_W-1:0]  maskWdata,
  input  logic               ctrlWe,
  input  logic [4:0]         ctrlWdata,
  input  logic               mstatWe,
  input  logic [MSTAT_W-1:0] mstatWdata,
  input  logic               fcWe,
  input  logic [MASK_W-1:0]  fcForce,
  input  logic [MASK_W-1:0]  fcClear,
  input  logic [ASTAT_W-1:0] astatIn,
  input  vecStrobe_t         strobe,
  output logic [SRC_N-1:0]   reqVec,
  output logic [MASK_W-1:0]  maskQ,
  output logic               nestMode,
  output logic [MSTAT_W-1:0] mstatQ,
  output logic               popValid,
  output logic [ASTAT_W-1:0] popAstat,
  output logic               ovfErr,
  output logic               unfErr
);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int ENT_W = ASTAT_W + MSTAT_W + MASK_W;

  logic [4:0] ctrlQ;
  logic [2:0] prevN;
  logic [2:0] fallN;
  logic [2:0] edgeMode;
  logic       startQ;

  assign edgeMode = ctrlQ[2:0];
  assign nestMode = ctrlQ[4];
  assign fallN    = prevN & ~irqN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevN  <= 3'b111;
      ctrlQ  <= '0;
      startQ <= 1'b1;
    end else begin
      prevN <= irqN;
      if (ctrlWe) ctrlQ <= ctrlWdata;
      if (strobe.ackHot[0]) startQ <= 1'b0;
    end
  end

  assign reqVec[0] = startQ;

  // per-source detection stage
  for (genvar i = 1; i < SRC_N; i++) begin : g_src
    localparam bit IS_HOST   = (i == 2) || (i == 3);
    localparam bit MAYBE_PIN = (i == 1) || (i == 6) || (i == 7);
    localparam int PIN       = (i == 1) ? 2 : ((i == 6) ? 1 : 0);
    logic evtHit, onPin, isLevel, softOk, setHit, clrHit, q;

    if (i == 1) begin : g_noevt
      assign evtHit = 1'b0;
    end else begin : g_evt
      assign evtHit = periphEvt[i-2];
    end

    if (i == 1) begin : g_fixpin
      assign onPin = 1'b1;
    end else if (MAYBE_PIN) begin : g_altpin
      assign onPin = altPins;
    end else begin : g_nopin
      assign onPin = 1'b0;
    end

    assign isLevel = onPin & ~edgeMode[PIN];
    assign softOk  = !IS_HOST && !isLevel;
    assign setHit  = (onPin ? fallN[PIN] : evtHit) | (fcWe & fcForce[i-1] & softOk);
    assign clrHit  = strobe.ackHot[i] | (fcWe & fcClear[i-1] & softOk);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        q <= 1'b0;
      else if (isLevel) q <= 1'b0;
      else if (setHit)  q <= 1'b1;
      else if (clrHit)  q <= 1'b0;
    end

    assign reqVec[i] = isLevel ? ~irqN[PIN] : q;
  end

  // status stack
  logic [CNT_W-1:0] sp;
  logic [ENT_W-1:0] stackMem [STACK_DEPTH];
  logic             roomLeft, doPush, doPop;
  logic [ENT_W-1:0] topEnt;

  assign roomLeft = (sp != CNT_W'(STACK_DEPTH));
  assign doPush   = strobe.push && roomLeft;
  assign doPop    = strobe.pop && (sp != '0);
  assign topEnt   = stackMem[PTR_W'(sp - 1'b1)];

  always_ff @(posedge clk) begin
    if (doPush) stackMem[PTR_W'(sp)] <= {astatIn, mstatQ, maskQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp       <= '0;
      maskQ    <= '0;
      mstatQ   <= '0;
      popValid <= 1'b0;
      popAstat <= '0;
      ovfErr   <= 1'b0;
      unfErr   <= 1'b0;
    end else begin
      popValid <= doPop;
      if (doPush) sp <= sp + 1'b1;
      if (doPop) begin
        sp       <= sp - 1'b1;
        popAstat <= topEnt[ENT_W-1 -: ASTAT_W];
        mstatQ   <= topEnt[MASK_W +: MSTAT_W];
        maskQ    <= topEnt[MASK_W-1:0];
      end else begin
        if (maskWe)  maskQ  <= maskWdata;
        if (mstatWe) mstatQ <= mstatWdata;
      end
      if (strobe.push && !roomLeft) ovfErr <= 1'b1;
      if (strobe.pop && sp == '0)   unfErr <= 1'b1;
    end
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);

  // R10
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && sp == CNT_W'(STACK_DEPTH)) |=> (ovfErr && $stable(sp)));

  // R9
  pop_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && sp != '0) |=> popValid);
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_vector_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  reqVec,
  input  logic [MASK_W-1:0] maskIn,
  input  logic              nestMode,
  input  logic              ack,
  input  logic              rti,
  output vecStrobe_t        strobe,
  output logic              irqValid,
  output logic [ADDR_W-1:0] vecAddr
);
  logic [SRC_N-1:0]     activeQ;
  logic [SRC_N-1:0]     elig;
  logic [SRC_N-1:0]     lowBit;
  logic [SRC_IDX_W-1:0] selIdx;
  logic                 anyElig;
  logic                 ackFire;

  always_comb begin
    logic seenAct;
    seenAct = 1'b0;
    elig    = '0;
    elig[0] = reqVec[0];
    for (int i = 1; i < SRC_N; i++) begin
      seenAct = seenAct | activeQ[i];
      elig[i] = reqVec[i] & maskIn[i-1] & (nestMode ? !seenAct : !(|activeQ));
    end
  end

  always_comb begin
    selIdx  = '0;
    anyElig = 1'b0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        selIdx  = SRC_IDX_W'(i);
        anyElig = 1'b1;
      end
    end
  end

  assign irqValid = anyElig;
  assign vecAddr  = anyElig ? ADDR_W'(32'(selIdx) * VEC_STRIDE) : '0;
  assign ackFire  = ack && !rti && anyElig;

  always_comb begin
    strobe        = '0;
    strobe.pop    = rti;
    strobe.push   = ackFire && (selIdx != '0);
    if (ackFire) strobe.ackHot[selIdx] = 1'b1;
  end

  assign lowBit = activeQ & (~activeQ + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        activeQ <= '0;
    else if (rti)     activeQ <= activeQ & ~lowBit;
    else if (ackFire) activeQ <= activeQ | (strobe.ackHot & ~SRC_N'(1));
  end

  // R7
  seq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!nestMode && (|activeQ)) |-> (!irqValid || selIdx == '0));

  // R3
  mask_honor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && selIdx != '0) |-> maskIn[selIdx - 1'b1]);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int VEC_STRIDE = 4,
  parameter int ASTAT_W = 8,
  parameter int MSTAT_W = 7,
  parameter int STACK_DEPTH = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         irqN,
  input  logic [6:0]         periphEvt,
  input  logic               altPins,
  input  logic               maskWe,
  input  logic [MASK_W-1:0]  maskWdata,
  input  logic               ctrlWe,
  input  logic [4:0]         ctrlWdata,
  input  logic               mstatWe,
  input  logic [MSTAT_W-1:0] mstatWdata,
  input  logic               fcWe,
  input  logic [MASK_W-1:0]  fcForce,
  input  logic [MASK_W-1:0]  fcClear,
  input  logic [ASTAT_W-1:0] astatIn,
  input  logic               ack,
  input  logic               rti,
  output logic               irqValid,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [MASK_W-1:0]  maskOut,
  output logic [MSTAT_W-1:0] mstatOut,
  output logic               popValid,
  output logic [ASTAT_W-1:0] popAstat,
  output logic               ovfErr,
  output logic               unfErr
);
  vecStrobe_t       strobe;
  logic [SRC_N-1:0] reqVec;
  logic             nestMode;

  irq_vector_dp #(
    .ASTAT_W(ASTAT_W), .MSTAT_W(MSTAT_W), .STACK_DEPTH(STACK_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqN(irqN), .periphEvt(periphEvt), .altPins(altPins),
    .maskWe(maskWe), .maskWdata(maskWdata), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .mstatWe(mstatWe), .mstatWdata(mstatWdata), .fcWe(fcWe), .fcForce(fcForce),
    .fcClear(fcClear), .astatIn(astatIn), .strobe(strobe), .reqVec(reqVec),
    .maskQ(maskOut), .nestMode(nestMode), .mstatQ(mstatOut), .popValid(popValid),
    .popAstat(popAstat), .ovfErr(ovfErr), .unfErr(unfErr)
  );

  irq_vector_seq #(
    .ADDR_W(ADDR_W), .VEC_STRIDE(VEC_STRIDE)
  ) u_seq (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .maskIn(maskOut), .nestMode(nestMode),
    .ack(ack), .rti(rti), .strobe(strobe), .irqValid(irqValid), .vecAddr(vecAddr)
  );
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] irqN = 3'b111;
  logic [6:0] periphEvt = '0;
  logic altPins = 1'b0;
  logic maskWe = 1'b0;
  logic [7:0] maskWdata = '0;
  logic ctrlWe = 1'b0;
  logic [4:0] ctrlWdata = '0;
  logic mstatWe = 1'b0;
  logic [6:0] mstatWdata = '0;
  logic fcWe = 1'b0;
  logic [7:0] fcForce = '0, fcClear = '0;
  logic [7:0] astatIn = '0;
  logic ack = 1'b0, rti = 1'b0;

  logic irqValid, popValid, ovfErr, unfErr;
  logic [13:0] vecAddr;
  logic [7:0] maskOut, popAstat;
  logic [6:0] mstatOut;

  logic sIrqValid, sPopValid, sOvf, sUnf;
  logic [13:0] sVec;
  logic [7:0] sMask, sPopAstat;
  logic [6:0] sMstat;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .irqN(irqN), .periphEvt(periphEvt), .altPins(altPins),
    .maskWe(maskWe), .maskWdata(maskWdata), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .mstatWe(mstatWe), .mstatWdata(mstatWdata), .fcWe(fcWe), .fcForce(fcForce),
    .fcClear(fcClear), .astatIn(astatIn), .ack(ack), .rti(rti),
    .irqValid(irqValid), .vecAddr(vecAddr), .maskOut(maskOut), .mstatOut(mstatOut),
    .popValid(popValid), .popAstat(popAstat), .ovfErr(ovfErr), .unfErr(unfErr)
  );

  irq_vector_ctrl #(.STACK_DEPTH(2)) u_irq_vector_ctrl_d2 (
    .clk(clk), .rstN(rstN), .irqN(irqN), .periphEvt(periphEvt), .altPins(altPins),
    .maskWe(maskWe), .maskWdata(maskWdata), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .mstatWe(mstatWe), .mstatWdata(mstatWdata), .fcWe(fcWe), .fcForce(fcForce),
    .fcClear(fcClear), .astatIn(astatIn), .ack(ack), .rti(rti),
    .irqValid(sIrqValid), .vecAddr(sVec), .maskOut(sMask), .mstatOut(sMstat),
    .popValid(sPopValid), .popAstat(sPopAstat), .ovfErr(sOvf), .unfErr(sUnf)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // presented vector packed with valid: {valid, addr}
  function automatic logic [31:0] expPres(input int idx);
    if (idx < 0) return 32'h0;
    return 32'h10000 | 32'(idx * 4);
  endfunction

  function automatic int pickTop(input logic [8:0] pend, input logic [7:0] m);
    if (pend[0]) return 0;
    for (int k = 1; k < 9; k++) if (pend[k] && m[k-1]) return k;
    return -1;
  endfunction

  function automatic logic [31:0] pres();
    return irqValid ? (32'h10000 | 32'(vecAddr)) : 32'h0;
  endfunction

  task automatic doReset();
    rstN = 1'b0; irqN = 3'b111; periphEvt = '0; altPins = 1'b0; astatIn = '0;
    ack = 1'b0; rti = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic wrMask(input logic [7:0] m);
    maskWe = 1'b1; maskWdata = m; tick(); maskWe = 1'b0;
  endtask
  task automatic wrCtrl(input logic [4:0] c);
    ctrlWe = 1'b1; ctrlWdata = c; tick(); ctrlWe = 1'b0;
  endtask
  task automatic wrMstat(input logic [6:0] v);
    mstatWe = 1'b1; mstatWdata = v; tick(); mstatWe = 1'b0;
  endtask
  task automatic wrFc(input logic [7:0] f, input logic [7:0] c);
    fcWe = 1'b1; fcForce = f; fcClear = c; tick(); fcWe = 1'b0; fcForce = '0; fcClear = '0;
  endtask
  task automatic pulseEvt(input logic [6:0] e);
    periphEvt = e; tick(); periphEvt = '0;
  endtask
  task automatic ackNow();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask
  task automatic rtiNow();
    rti = 1'b1; tick(); rti = 1'b0;
  endtask
  task automatic fresh();
    doReset(); ackNow(); wrMask(8'hFF);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));

    // R1 reset state
    doReset();
    chk("R1 startup vector", pres(), expPres(0));
    chk("R1 mask", 32'(maskOut), 32'h0);
    chk("R1 mstat", 32'(mstatOut), 32'h0);
    chk("R1 errors", {30'd0, ovfErr, unfErr}, 32'h0);
    ackNow();
    chk("R1 idle after startup", pres(), 32'h0);
    pulseEvt(7'h40);
    chk("R1 timer masked", pres(), 32'h0);
    wrMask(8'hFF);
    chk("R3 timer unmasked", pres(), expPres(8));
    ackNow(); rtiNow();

    // R2 R3 random priority and mask
    for (int it = 0; it < 20; it++) begin
      logic [8:0] pend;
      logic [7:0] m;
      logic [6:0] e;
      doReset(); ackNow();
      m = 8'($urandom);
      e = 7'($urandom);
      if (it == 0) begin m = 8'hFF; e = 7'h7F; end
      wrMask(m);
      pulseEvt(e);
      pend = {e, 2'b00};
      for (int n = 0; n < 9; n++) begin
        int t;
        t = pickTop(pend, m);
        chk("R2 R3 random vector", pres(), expPres(t));
        if (t < 0) break;
        ackNow();
        pend[t] = 1'b0;
        rtiNow();
      end
    end

    // R4 edge-mode pin
    fresh();
    wrCtrl(5'b00100);
    irqN[2] = 1'b0; tick(); irqN[2] = 1'b1; tick();
    chk("R4 edge latched", pres(), expPres(1));
    ackNow(); rtiNow();
    chk("R4 retired by ack", pres(), 32'h0);

    // R5 level-mode pin
    fresh();
    irqN[2] = 1'b0; #1;
    chk("R5 level low", pres(), expPres(1));
    ackNow(); rtiNow();
    chk("R5 ack does not retire", pres(), expPres(1));
    irqN[2] = 1'b1; #1;
    chk("R5 level released", pres(), 32'h0);

    // R6 force and clear
    fresh();
    wrFc(8'h80, 8'h00);
    chk("R6 force timer", pres(), expPres(8));
    wrFc(8'h00, 8'h80);
    chk("R6 clear timer", pres(), 32'h0);
    wrFc(8'h02, 8'h00);
    chk("R6 host ignores force", pres(), 32'h0);
    wrFc(8'h01, 8'h00);
    chk("R6 level pin ignores force", pres(), 32'h0);
    wrCtrl(5'b00100);
    wrFc(8'h01, 8'h00);
    chk("R6 edge pin forced", pres(), expPres(1));
    wrFc(8'h00, 8'h01);
    chk("R6 edge pin cleared", pres(), 32'h0);

    // R7 sequential servicing
    fresh();
    pulseEvt(7'h40);
    ackNow();
    pulseEvt(7'h04);
    chk("R7 blocked while active", pres(), 32'h0);
    rtiNow();
    chk("R7 next after return", pres(), expPres(4));
    ackNow(); rtiNow();

    // R8 nesting with R9 R10 on the shallow instance
    fresh();
    wrCtrl(5'b10000);
    pulseEvt(7'h40);
    astatIn = 8'h01; ackNow();
    pulseEvt(7'h08);
    chk("R8 preempt by serial-0 receive", pres(), expPres(5));
    astatIn = 8'h02; ackNow();
    pulseEvt(7'h04);
    chk("R8 preempt by serial-0 transmit", pres(), expPres(4));
    astatIn = 8'h03; ackNow();
    chk("R10 shallow overflow", 32'(sOvf), 32'h1);
    chk("R10 deep no overflow", 32'(ovfErr), 32'h0);
    pulseEvt(7'h40);
    chk("R8 lower blocked", pres(), 32'h0);
    rtiNow();
    chk("R9 pop order 3", 32'(popAstat), 32'h03);
    chk("R10 shallow keeps entries", 32'(sPopAstat), 32'h02);
    chk("R8 still blocked", pres(), 32'h0);
    rtiNow();
    chk("R9 pop order 2", 32'(popAstat), 32'h02);
    chk("R10 shallow second", 32'(sPopAstat), 32'h01);
    rtiNow();
    chk("R9 pop order 1", 32'(popAstat), 32'h01);
    chk("R10 shallow underflow", 32'(sUnf), 32'h1);
    chk("R8 timer after returns", pres(), expPres(8));

    // R9 save and restore
    fresh();
    wrMstat(7'h15);
    pulseEvt(7'h40);
    astatIn = 8'hA5; ackNow(); astatIn = 8'h00;
    wrMask(8'h80); wrMstat(7'h0A);
    chk("R9 mask rewritten", 32'(maskOut), 32'h80);
    rtiNow();
    chk("R9 mask restored", 32'(maskOut), 32'hFF);
    chk("R9 mstat restored", 32'(mstatOut), 32'h15);
    chk("R9 pop valid", 32'(popValid), 32'h1);
    chk("R9 astat returned", 32'(popAstat), 32'hA5);
    tick();
    chk("R9 pop valid one cycle", 32'(popValid), 32'h0);
    rtiNow();
    chk("R10 underflow flag", 32'(unfErr), 32'h1);
    chk("R10 mask kept on underflow", 32'(maskOut), 32'hFF);
    tick();
    chk("R10 underflow sticky", 32'(unfErr), 32'h1);
    doReset();
    chk("R1 reset clears flag", 32'(unfErr), 32'h0);
    chk("R1 reset clears mask", 32'(maskOut), 32'h0);
    chk("R1 reset clears mstat", 32'(mstatOut), 32'h0);

    // R11 same-cycle edge and acknowledge
    fresh();
    wrCtrl(5'b00100);
    irqN[2] = 1'b0; tick(); irqN[2] = 1'b1; tick();
    ack = 1'b1; irqN[2] = 1'b0; tick(); ack = 1'b0; irqN[2] = 1'b1;
    rtiNow();
    chk("R11 new edge survives ack", pres(), expPres(1));
    ackNow(); rtiNow();
    chk("R11 then retired", pres(), 32'h0);

    // R11 ack together with return
    fresh();
    pulseEvt(7'h40);
    ack = 1'b1; rti = 1'b1; tick(); ack = 1'b0; rti = 1'b0;
    chk("R11 return taken", 32'(unfErr), 32'h1);
    chk("R11 ack ignored", pres(), expPres(8));

    // R12 alternate pin routing
    fresh();
    wrCtrl(5'b00010);
    altPins = 1'b1;
    pulseEvt(7'h10);
    chk("R12 serial event ignored", pres(), 32'h0);
    irqN[1] = 1'b0; tick(); irqN[1] = 1'b1; tick();
    chk("R12 IRQ1 on slot 6", pres(), expPres(6));
    ackNow(); rtiNow();
    altPins = 1'b0;
    irqN[0] = 1'b0; #1;
    chk("R12 pin ignored", pres(), 32'h0);
    pulseEvt(7'h20);
    chk("R12 serial-1 receive", pres(), expPres(7));
    irqN[0] = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule